// File: doc/BRIEF.md
# Signed Fraction-by-Integer Multiplier

This combinational datapath block multiplies an 8-bit two's complement integer by an 8-bit two's complement fraction. The fraction has its binary point directly below the sign bit, so the sign bit weighs -1 and the lower bits weigh 1/2, 1/4 and so on down to 1/128. The fraction therefore covers -1 up to 1 - 1/128.

The block forms the full 16-bit signed product. It returns the whole-number part as an 8-bit signed integer, which is bits 14..7 of the product. The seven fraction bits are dropped, and so is bit 15. The result is therefore floor(a*f/128), wrapped to 8 bits.

It sits in the processor's execute path. Coordinate scaling uses its result as the integer term. The full product is brought out so it can be tested. Rounding is truncation only. There is no overflow flag.

Top module: `frac_int_mul`

## Requirements
- R1: `prod_o` equals the 16-bit two's complement product of `int_i` and `frac_i`, both sign-extended as signed operands.
- R2: `res_o` equals `prod_o[14:7]`, which is floor(int*frac_raw/128) reduced modulo 256 and read as signed.
- R3: Fraction bits are discarded. Frac 0x60 (0.75) times int 6 gives `res_o` = 4.
- R4: Negative results round toward minus infinity. Frac 0xE0 (-0.25) times int 20 gives `res_o` = 0xFB (-5).
- R5: Int 0x80 (-128) times frac 0x80 (-1) gives `prod_o` = 0x4000 and `res_o` = 0x80, because the result wraps.
- R6: If either operand is zero, both `prod_o` and `res_o` are zero.
- R7: Frac 0x80 (-1) gives `prod_o` = -(int*128) modulo 2^16, so every operand is sign-extended and never zero-extended.
- R8: The block holds no state. The outputs reflect new operands with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| int_i | input | 8 | Signed integer operand |
| frac_i | input | 8 | Signed fraction operand, binary point below bit 7 |
| prod_o | output | 16 | Full signed product |
| res_o | output | 8 | Signed integer part of the product |

## Verification
The wrap case is hard to reach because it needs both operands at their most negative codes at once. The same holds for negative products with nonzero low bits, where floor and truncation toward zero differ. Directed vectors hit 0x80 x 0x80 and the worked examples first. An exhaustive sweep of all 65,536 operand pairs follows, so every sign combination and every discarded-fraction pattern meets the floor-based model.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  localparam int unsigned INT_W_DEF  = 8;
  localparam int unsigned FRAC_W_DEF = 8;

  function automatic int unsigned prod_w(input int unsigned iw, input int unsigned fw);
    return iw + fw;
  endfunction
endpackage

// File: rtl/fmul_pp_gen.sv
// Shifted, sign-extended partial products; the row for the sign bit is negated.
module fmul_pp_gen #(
  parameter int unsigned AW = 8,
  parameter int unsigned BW = 8,
  localparam int unsigned PW = AW + BW
) (
  input  logic [AW-1:0]          a_i,
  input  logic [BW-1:0]          b_i,
  output logic [BW-1:0][PW-1:0]  rows_o
);
  logic [PW-1:0] a_ext;
  assign a_ext = {{(PW-AW){a_i[AW-1]}}, a_i};

  always_comb begin
    for (int i = 0; i < int'(BW); i++) begin
      if (!b_i[i])              rows_o[i] = '0;
      else if (i == int'(BW)-1) rows_o[i] = ~(a_ext << i) + PW'(1);
      else                      rows_o[i] = a_ext << i;
    end
  end
endmodule

// File: rtl/fmul_row_sum.sv
module fmul_row_sum #(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = 16
) (
  input  logic [N-1:0][PW-1:0] rows_i,
  output logic [PW-1:0]        sum_o
);
  logic [PW-1:0] acc [N+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_acc
    assign acc[i+1] = acc[i] + rows_i[i];
  end

  assign sum_o = acc[N];
endmodule

// File: rtl/fmul_core.sv
// USE_ARRAY=1 builds an explicit add array; 0 infers one signed multiplier.
module fmul_core #(
  parameter int unsigned AW        = 8,
  parameter int unsigned BW        = 8,
  parameter bit          USE_ARRAY = 1'b1,
  localparam int unsigned PW = AW + BW
) (
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [PW-1:0] p_o
);
  if (USE_ARRAY) begin : g_array
    logic [BW-1:0][PW-1:0] rows;
    fmul_pp_gen #(.AW(AW), .BW(BW)) i_pp (.a_i(a_i), .b_i(b_i), .rows_o(rows));
    fmul_row_sum #(.N(BW), .PW(PW)) i_sum (.rows_i(rows), .sum_o(p_o));
  end else begin : g_infer
    logic signed [PW-1:0] sa, sb;
    assign sa  = {{(PW-AW){a_i[AW-1]}}, a_i};
    assign sb  = {{(PW-BW){b_i[BW-1]}}, b_i};
    assign p_o = sa * sb;
  end
endmodule

// File: rtl/frac_int_mul.sv
module frac_int_mul
  import fmul_pkg::*;
#(
  parameter int unsigned INT_W     = INT_W_DEF,
  parameter int unsigned FRAC_W    = FRAC_W_DEF,
  parameter bit          USE_ARRAY = 1'b1,
  localparam int unsigned PW = prod_w(INT_W, FRAC_W),
  localparam int unsigned FB = FRAC_W - 1
) (
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [PW-1:0]     prod_o,
  output logic [INT_W-1:0]  res_o
);
  fmul_core #(.AW(INT_W), .BW(FRAC_W), .USE_ARRAY(USE_ARRAY)) i_core (
    .a_i(int_i), .b_i(frac_i), .p_o(prod_o)
  );

  // drop sign-duplicate top bit and the fraction bits
  assign res_o = prod_o[FB+INT_W-1:FB];

  localparam logic [INT_W-1:0]  INT_MIN  = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [FRAC_W-1:0] FRAC_MIN = {1'b1, {(FRAC_W-1){1'b0}}};
  logic [PW-1:0] neg_int_scaled;
  assign neg_int_scaled = PW'(0) - ({{(PW-INT_W){int_i[INT_W-1]}}, int_i} << FB);

  always_comb begin
    if (int_i == '0 || frac_i == '0)
      a_r6_zero: assert (prod_o == '0 && res_o == '0);
    if (int_i == INT_MIN && frac_i == FRAC_MIN)
      a_r5_wrap: assert (res_o == INT_MIN);
    if (frac_i == FRAC_MIN)
      a_r7_neg_one: assert (prod_o == neg_int_scaled);
    if (int_i != '0 && frac_i != '0 && !(int_i == INT_MIN && frac_i == FRAC_MIN))
      a_r1_sign: assert (prod_o[PW-1] == (int_i[INT_W-1] ^ frac_i[FRAC_W-1]));
  end
endmodule

// File: tb/test_frac_int_mul.sv
module test_frac_int_mul;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  int_i, frac_i;
  logic [15:0] prod_o;
  logic [7:0]  res_o;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  frac_int_mul i_frac_int_mul (.int_i(int_i), .frac_i(frac_i), .prod_o(prod_o), .res_o(res_o));

  function automatic void model(input logic [7:0] a, input logic [7:0] f,
                                output logic [15:0] p, output logic [7:0] r);
    int pr, q;
    pr = int'($signed(a)) * int'($signed(f));
    q  = pr / 128;
    if (pr < 0 && (pr % 128) != 0) q = q - 1;
    p = pr[15:0];
    r = q[7:0];
  endfunction

  task automatic apply(input logic [7:0] a, input logic [7:0] f, input string tag);
    logic [15:0] ep;
    logic [7:0]  er;
    @(negedge clk);
    int_i = a; frac_i = f;
    #1;  // combinational: no edge in between (R8)
    model(a, f, ep, er);
    n_cmp++;
    if (prod_o !== ep || res_o !== er) begin
      n_bad++;
      $display("FAIL %s a=%02h f=%02h prod=%04h exp %04h res=%02h exp %02h",
               tag, a, f, prod_o, ep, res_o, er);
    end
  endtask

  task automatic expect_res(input logic [7:0] exp_r, input string tag);
    n_cmp++;
    if (res_o !== exp_r) begin
      n_bad++;
      $display("FAIL %s res=%02h exp %02h", tag, res_o, exp_r);
    end
  endtask

  initial begin
    int_i = '0; frac_i = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    apply(8'h00, 8'h00, "R6 reset idle");
    apply(8'h06, 8'h60, "R3");       expect_res(8'h04, "R3 0.75*6");
    apply(8'h14, 8'hE0, "R4");       expect_res(8'hFB, "R4 -0.25*20");
    apply(8'h80, 8'h80, "R5");       expect_res(8'h80, "R5 wrap");
    n_cmp++;
    if (prod_o !== 16'h4000) begin
      n_bad++; $display("FAIL R5 prod=%04h exp 4000", prod_o);
    end
    apply(8'h00, 8'h7F, "R6 int zero");
    apply(8'h80, 8'h00, "R6 frac zero");
    apply(8'h7F, 8'h80, "R7 max int");
    apply(8'hFF, 8'h80, "R7 minus one");
    apply(8'hFF, 8'h01, "R4 tiny neg");  expect_res(8'hFF, "R4 floor -1/128");
    apply(8'h7F, 8'h7F, "R1 max pos");
    // R8: back-to-back changes within one clock period
    @(negedge clk);
    int_i = 8'h10; frac_i = 8'h40; #1; expect_res(8'h08, "R8 first");
    int_i = 8'hF0; #1;                 expect_res(8'hF8, "R8 second");
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 256; f++)
        apply(a[7:0], f[7:0], "R1 R2 sweep");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule